// File: doc/BRIEF.md
# GPIO Function Crossbar

This block sits between 64 internal GPIO lines and a set of on-chip peripheral ports. Every connection is chosen at its destination. Each GPIO line holds two select fields: one names the source of its output value and one names the source of its output enable. Each source is a peripheral output or a constant 0 or 1. Each peripheral input likewise holds one select field that names a GPIO input or a constant. A constant is always a legal choice, so any destination can be parked without touching the others.

The GPIO inputs also pass through a two-flop synchronizer. The synchronized levels can be read back through two 32-bit words. They also feed a per-line interrupt detector, which is level- or edge-sensitive and has its own enable and a write-one-to-clear status bit. The out-of-reset routing connects the CPU debug port to GPIO lines 0 to 4. The port's data output leaves on line 0, with its enable forced high. Clock, data-in, mode select and active-low reset enter on lines 1, 2, 3 and 4, and go to peripheral inputs 0 to 3.

Top module: `gpio_route_xbar`

## Requirements
- R1: Out of reset, gpio_out[0] follows periph_out[0] and gpio_oe[0] is 1. Every other gpio_out and gpio_oe bit is 0. periph_in[3:0] follow gpio_in[4:1], and every other periph_in bit is 0.
- R2: An output select (word 0x000+n for line n) is decoded as follows. 0 gives constant 0, 1 gives constant 1, and 2+k gives periph_out[k]. Any value at or above 2+N_POUT gives 0.
- R3: An output-enable select (word 0x040+n) drives gpio_oe[n] with the same encoding as R2.
- R4: An input select (word 0x080+j) drives periph_in[j] combinationally. 0 gives constant 0, 1 gives constant 1, and 2+k gives gpio_in[k]. Any value at or above 66 gives 0.
- R5: Word 0x100 reads the synchronized levels of lines 0..31, and word 0x101 reads lines 32..63, with line n at bit n mod 32. A level applied to gpio_in is visible after the second rising clock edge, and not after the first.
- R6: A line whose mode bit is 1 (words 0x104/0x105) is edge-sensitive. A synchronized rising transition on an enabled line sets its status bit (words 0x106/0x107) at the third rising edge after the pin change. A line that is held high or falls sets nothing.
- R7: A line whose mode bit is 0 is level-sensitive. Its status bit is set on every cycle in which its synchronized level is 1 and its enable is 1. This means a clear has no lasting effect while the level stays high.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new detection fall in the same cycle, the bit stays set.
- R9: irq is 1 exactly when some status bit and its enable bit (words 0x102/0x103) are both 1. A line whose enable is 0 never sets its status bit. Clearing an enable masks irq but keeps the status bit.
- R10: Select words read back the value written, truncated to the field width (output and enable selects 5 bits, input selects 7 bits at default parameters). Unmapped words read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 9 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| gpio_in | input | 64 | Input levels of the GPIO lines |
| gpio_out | output | 64 | Output values of the GPIO lines |
| gpio_oe | output | 64 | Output enables of the GPIO lines |
| periph_out | input | N_POUT (16) | Peripheral output signals, the sources for GPIO out and enable |
| periph_in | output | N_PIN (16) | Peripheral input signals, each taken from a GPIO line or a constant |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can meet in one cycle: a software write-one-to-clear of a status bit, and the detector setting that same bit. The bench provokes this on an edge-mode line. It raises the pin, then places the clear write so that the write strobe is high on exactly the third rising edge after the pin change. A status read that still shows the bit confirms that detection takes priority. A clear issued alone afterwards must remove the bit. The level-mode line repeats the collision in a steady state, because a clear issued while the level is high always meets a new detection.

// File: rtl/gxb_pkg.sv
package gxb_pkg;
  localparam int unsigned NUM_LINES  = 64;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned ADDR_W     = 9;
  localparam int unsigned SEL_OFFSET = 2;

  localparam logic [ADDR_W-1:0] BASE_OUT_SEL = 9'h000;
  localparam logic [ADDR_W-1:0] BASE_OE_SEL  = 9'h040;
  localparam logic [ADDR_W-1:0] BASE_IN_SEL  = 9'h080;
  localparam logic [ADDR_W-1:0] ADR_LVL_LO   = 9'h100;
  localparam logic [ADDR_W-1:0] ADR_LVL_HI   = 9'h101;
  localparam logic [ADDR_W-1:0] ADR_ENA_LO   = 9'h102;
  localparam logic [ADDR_W-1:0] ADR_ENA_HI   = 9'h103;
  localparam logic [ADDR_W-1:0] ADR_MODE_LO  = 9'h104;
  localparam logic [ADDR_W-1:0] ADR_MODE_HI  = 9'h105;
  localparam logic [ADDR_W-1:0] ADR_STAT_LO  = 9'h106;
  localparam logic [ADDR_W-1:0] ADR_STAT_HI  = 9'h107;

  // Debug port wiring out of reset
  localparam int unsigned DBG_DOUT_SRC = 0;  // peripheral output index
  localparam int unsigned DBG_IN_FIRST = 0;  // first peripheral input index
  localparam int unsigned DBG_IN_COUNT = 4;  // clock, data-in, mode, reset
  localparam int unsigned DBG_IN_LINE0 = 1;  // GPIO line feeding first input
endpackage

// File: rtl/gxb_sel_mux.sv
module gxb_sel_mux #(
  parameter int unsigned SRC_N = 16,
  parameter int unsigned SEL_W = 5
) (
  input  logic [SRC_N-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);
  always_comb begin
    y = 1'b0;
    if (sel == SEL_W'(1)) begin
      y = 1'b1;
    end
    for (int k = 0; k < int'(SRC_N); k++) begin
      if (sel == SEL_W'(k + int'(gxb_pkg::SEL_OFFSET))) begin
        y = src[k];
      end
    end
  end
endmodule

// File: rtl/gxb_irq.sv
module gxb_irq #(
  parameter int unsigned LINES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_raw,
  input  logic [LINES-1:0] en,
  input  logic [LINES-1:0] mode,
  input  logic [LINES-1:0] clr,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] status,
  output logic             irq
);
  logic [LINES-1:0] sync1_q, sync2_q, prev_q, status_q;
  logic [LINES-1:0] hit, status_d;
  logic [1:0]       age_q, age_d;

  always_comb begin
    hit      = en & ((mode & sync2_q & ~prev_q) | (~mode & sync2_q));
    status_d = (status_q & ~clr) | hit;
    age_d    = (age_q == 2'd2) ? age_q : age_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      prev_q   <= '0;
      status_q <= '0;
      age_q    <= '0;
    end else begin
      sync1_q  <= pin_raw;
      sync2_q  <= sync1_q;
      prev_q   <= sync2_q;
      status_q <= status_d;
      age_q    <= age_d;
    end
  end

  assign lvl    = sync2_q;
  assign status = status_q;
  assign irq    = |(status_q & en);

  AST_LVL_TWO_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync2_q == $past(pin_raw, 2))); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr)) == $past(status_q & ~clr))); // R8
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) & ~$past(en)) == '0); // R9
  AST_EDGE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) & $past(mode) & $past(prev_q)) == '0); // R6
  AST_LEVEL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) & ~$past(sync2_q)) == '0); // R7
endmodule

// File: rtl/gpio_route_xbar.sv
module gpio_route_xbar
  import gxb_pkg::*;
#(
  parameter int unsigned N_POUT = 16,
  parameter int unsigned N_PIN  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [8:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [63:0]          gpio_in,
  output logic [63:0]          gpio_out,
  output logic [63:0]          gpio_oe,
  input  logic [N_POUT-1:0]    periph_out,
  output logic [N_PIN-1:0]     periph_in,
  output logic                 irq
);
  localparam int unsigned OSEL_W = $clog2(N_POUT + SEL_OFFSET);
  localparam int unsigned ISEL_W = $clog2(NUM_LINES + SEL_OFFSET);
  localparam int unsigned HALF   = NUM_LINES / 2;

  logic [OSEL_W-1:0] out_sel_q [NUM_LINES];
  logic [OSEL_W-1:0] out_sel_d [NUM_LINES];
  logic [OSEL_W-1:0] oe_sel_q  [NUM_LINES];
  logic [OSEL_W-1:0] oe_sel_d  [NUM_LINES];
  logic [ISEL_W-1:0] in_sel_q  [N_PIN];
  logic [ISEL_W-1:0] in_sel_d  [N_PIN];
  logic [NUM_LINES-1:0] en_q, en_d, mode_q, mode_d, clr;
  logic [NUM_LINES-1:0] lvl, status;

  // Next-state: register writes
  always_comb begin
    out_sel_d = out_sel_q;
    oe_sel_d  = oe_sel_q;
    in_sel_d  = in_sel_q;
    en_d      = en_q;
    mode_d    = mode_q;
    clr       = '0;
    if (reg_we) begin
      for (int n = 0; n < int'(NUM_LINES); n++) begin
        if (reg_addr == BASE_OUT_SEL + ADDR_W'(n)) out_sel_d[n] = reg_wdata[OSEL_W-1:0];
        if (reg_addr == BASE_OE_SEL + ADDR_W'(n))  oe_sel_d[n]  = reg_wdata[OSEL_W-1:0];
      end
      for (int j = 0; j < int'(N_PIN); j++) begin
        if (reg_addr == BASE_IN_SEL + ADDR_W'(j)) in_sel_d[j] = reg_wdata[ISEL_W-1:0];
      end
      case (reg_addr)
        ADR_ENA_LO:  en_d[HALF-1:0]           = reg_wdata;
        ADR_ENA_HI:  en_d[NUM_LINES-1:HALF]   = reg_wdata;
        ADR_MODE_LO: mode_d[HALF-1:0]         = reg_wdata;
        ADR_MODE_HI: mode_d[NUM_LINES-1:HALF] = reg_wdata;
        ADR_STAT_LO: clr[HALF-1:0]            = reg_wdata;
        ADR_STAT_HI: clr[NUM_LINES-1:HALF]    = reg_wdata;
        default: ;
      endcase
    end
  end

  // Registers with debug-port reset routing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < int'(NUM_LINES); n++) begin
        out_sel_q[n] <= (n == 0) ? OSEL_W'(DBG_DOUT_SRC + SEL_OFFSET) : '0;
        oe_sel_q[n]  <= (n == 0) ? OSEL_W'(1) : '0;
      end
      for (int j = 0; j < int'(N_PIN); j++) begin
        in_sel_q[j] <= (j >= int'(DBG_IN_FIRST) && j < int'(DBG_IN_FIRST + DBG_IN_COUNT))
                       ? ISEL_W'(j - int'(DBG_IN_FIRST) + int'(DBG_IN_LINE0 + SEL_OFFSET)) : '0;
      end
      en_q   <= '0;
      mode_q <= '0;
    end else if (reg_we) begin
      out_sel_q <= out_sel_d;
      oe_sel_q  <= oe_sel_d;
      in_sel_q  <= in_sel_d;
      en_q      <= en_d;
      mode_q    <= mode_d;
    end
  end

  // Destination-side multiplexers
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    gxb_sel_mux #(.SRC_N(N_POUT), .SEL_W(OSEL_W)) u_out (
      .src(periph_out), .sel(out_sel_q[n]), .y(gpio_out[n]));
    gxb_sel_mux #(.SRC_N(N_POUT), .SEL_W(OSEL_W)) u_oe (
      .src(periph_out), .sel(oe_sel_q[n]), .y(gpio_oe[n]));
  end

  for (genvar j = 0; j < N_PIN; j++) begin : g_pin
    gxb_sel_mux #(.SRC_N(NUM_LINES), .SEL_W(ISEL_W)) u_in (
      .src(gpio_in), .sel(in_sel_q[j]), .y(periph_in[j]));
  end

  gxb_irq #(.LINES(NUM_LINES)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_raw(gpio_in), .en(en_q), .mode(mode_q),
    .clr(clr), .lvl(lvl), .status(status), .irq(irq));

  // Read mux
  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < int'(NUM_LINES); n++) begin
      if (reg_addr == BASE_OUT_SEL + ADDR_W'(n)) reg_rdata = 32'(out_sel_q[n]);
      if (reg_addr == BASE_OE_SEL + ADDR_W'(n))  reg_rdata = 32'(oe_sel_q[n]);
    end
    for (int j = 0; j < int'(N_PIN); j++) begin
      if (reg_addr == BASE_IN_SEL + ADDR_W'(j)) reg_rdata = 32'(in_sel_q[j]);
    end
    case (reg_addr)
      ADR_LVL_LO:  reg_rdata = lvl[HALF-1:0];
      ADR_LVL_HI:  reg_rdata = lvl[NUM_LINES-1:HALF];
      ADR_ENA_LO:  reg_rdata = en_q[HALF-1:0];
      ADR_ENA_HI:  reg_rdata = en_q[NUM_LINES-1:HALF];
      ADR_MODE_LO: reg_rdata = mode_q[HALF-1:0];
      ADR_MODE_HI: reg_rdata = mode_q[NUM_LINES-1:HALF];
      ADR_STAT_LO: reg_rdata = status[HALF-1:0];
      ADR_STAT_HI: reg_rdata = status[NUM_LINES-1:HALF];
      default: ;
    endcase
  end

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0)); // R9
endmodule

// File: tb/gpio_route_xbar_test.sv
`timescale 1ns/1ps
module gpio_route_xbar_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [8:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] gpio_in, gpio_out, gpio_oe;
  logic [15:0] periph_out, periph_in;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_route_xbar uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .periph_out(periph_out),
    .periph_in(periph_in), .irq(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
  endtask

  task automatic settle3();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    gpio_in = 64'h0000_0000_0000_0016;
    periph_out = 16'h0001;
    #0.5;
    chk("R1 gpio_out", gpio_out, 64'h1);
    chk("R1 gpio_oe", gpio_oe, 64'h1);
    chk("R1 periph_in", {48'h0, periph_in}, 64'h000B);
    periph_out = 16'h0000;
    gpio_in = 64'h0000_0000_0000_0008;
    #0.5;
    chk("R1 gpio_out follows", gpio_out, 64'h0);
    chk("R1 periph_in follows", {48'h0, periph_in}, 64'h0004);
    rd(9'h080, d);
    chk("R1 in_sel0 default", {32'h0, d}, 64'd3);
  endtask

  task automatic t_out_sel();
    logic [31:0] d;
    periph_out = 16'hFFFF;
    wr(9'h000 + 9'd10, 32'd31);
    wr(9'h000 + 9'd11, 32'd1);
    wr(9'h000 + 9'd12, 32'd9);
    periph_out = 16'h0080;
    #0.5;
    chk("R2 out-of-range sel", {63'h0, gpio_out[10]}, 64'h0);
    chk("R2 const1 sel", {63'h0, gpio_out[11]}, 64'h1);
    chk("R2 periph 7 high", {63'h0, gpio_out[12]}, 64'h1);
    periph_out = 16'h0000;
    #0.5;
    chk("R2 periph 7 low", {63'h0, gpio_out[12]}, 64'h0);
    rd(9'h00A, d);
    chk("R10 out sel readback", {32'h0, d}, 64'd31);
    wr(9'h0C0, 32'd5);
    rd(9'h0C0, d);
    chk("R10 unmapped word", {32'h0, d}, 64'h0);
    rd(9'h000 + 9'd63, d);
    chk("R10 unmapped write ignored", {32'h0, d}, 64'h0);
  endtask

  task automatic t_oe_sel();
    wr(9'h040 + 9'd63, 32'd17);
    wr(9'h040 + 9'd0, 32'd0);
    periph_out = 16'h8000;
    #0.5;
    chk("R3 oe from periph 15", gpio_oe, 64'h8000_0000_0000_0000);
    periph_out = 16'h7FFF;
    #0.5;
    chk("R3 oe periph 15 low", gpio_oe, 64'h0);
  endtask

  task automatic t_in_sel();
    logic [31:0] d;
    wr(9'h085, 32'd42);
    wr(9'h086, 32'd1);
    wr(9'h087, 32'd100);
    gpio_in = 64'h0000_0100_0000_0000;
    #0.5;
    chk("R4 in sel line 40 high", {61'h0, periph_in[7:5]}, 64'b011);
    gpio_in = 64'hFFFF_FEFF_FFFF_FFFF;
    #0.5;
    chk("R4 in sel line 40 low", {61'h0, periph_in[7:5]}, 64'b010);
    rd(9'h087, d);
    chk("R10 in sel readback", {32'h0, d}, 64'd100);
  endtask

  task automatic t_lvl();
    logic [31:0] lo, hi;
    @(negedge clk);
    gpio_in = 64'hA5A5_0000_0000_C3C3;
    @(posedge clk);
    @(negedge clk);
    reg_addr = 9'h100;
    #0.5 chk("R5 not after one edge", {32'h0, reg_rdata}, 64'hFFFF_FFFF);
    @(posedge clk);
    rd(9'h100, lo);
    rd(9'h101, hi);
    chk("R5 level words", {hi, lo}, 64'hA5A5_0000_0000_C3C3);
    chk("R9 no irq when disabled", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    gpio_in = 64'h0;
    wr(9'h104, 32'h0000_0020);
    wr(9'h102, 32'h0000_0020);
    repeat (3) @(negedge clk);
    gpio_in[5] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 not before third edge", {63'h0, irq}, 64'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 edge sets irq", {63'h0, irq}, 64'h1);
    wr(9'h106, 32'h0000_0020);
    settle3();
    rd(9'h106, d);
    chk("R6 held high sets nothing", {32'h0, d}, 64'h0);
    gpio_in[5] = 1'b0;
    settle3();
    rd(9'h106, d);
    chk("R6 fall sets nothing", {32'h0, d}, 64'h0);
    gpio_in[5] = 1'b1;
    settle3();
  endtask

  task automatic t_clear_race();
    logic [31:0] d;
    gpio_in[5] = 1'b0;
    settle3();
    rd(9'h106, d);
    chk("R8 status sticky", {32'h0, d}, 64'h20);
    gpio_in[5] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 9'h106; reg_wdata = 32'h0000_0020;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    rd(9'h106, d);
    chk("R8 set wins over clear", {32'h0, d}, 64'h20);
    wr(9'h106, 32'h0000_0000);
    rd(9'h106, d);
    chk("R8 write 0 keeps bit", {32'h0, d}, 64'h20);
    wr(9'h106, 32'h0000_0020);
    rd(9'h106, d);
    chk("R8 clear alone", {32'h0, d}, 64'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(9'h102, 32'h0);
    wr(9'h105, 32'h0);
    wr(9'h103, 32'h0000_0080);
    gpio_in[39] = 1'b1;
    settle3();
    chk("R7 level sets irq", {63'h0, irq}, 64'h1);
    wr(9'h107, 32'h0000_0080);
    rd(9'h107, d);
    chk("R7 clear while high", {32'h0, d}, 64'h80);
    wr(9'h103, 32'h0);
    chk("R9 masked irq", {63'h0, irq}, 64'h0);
    rd(9'h107, d);
    chk("R9 status kept when masked", {32'h0, d}, 64'h80);
    gpio_in[39] = 1'b0;
    settle3();
    wr(9'h107, 32'h0000_0080);
    wr(9'h103, 32'h0000_0080);
    settle3();
    chk("R7 low level no irq", {63'h0, irq}, 64'h0);
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    gpio_in = '0; periph_out = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_out_sel();
    t_oe_sel();
    t_in_sel();
    t_lvl();
    t_edge();
    t_clear_race();
    t_level();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule